// File: doc/BRIEF.md
# Two-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core for a small load/store integer instruction subset, organised as a two-stage pipeline. The first stage does nothing but fetch: it presents the program counter on the instruction port and captures the returned word. The second stage decodes that word, reads the register file, runs the ALU, performs any data access and writes the result back, all within one cycle. Both memory ports are answered combinationally by the surrounding system. Program completion is reported through a host status register that a test environment polls.

Taken branches and jumps resolve in the second stage. When they do, the word fetched in that same cycle is discarded and fetch restarts at the target on the following cycle, so a taken transfer costs one bubble. Because the register file is written on the clock edge that closes the second stage, the instruction behind it reads the new value with no stall and no bypass path.

Top module: `pipe2_core`

## Requirements
- R1: An instruction fetched in cycle n executes in cycle n+1; a chain of back-to-back dependent instructions yields the correct result with no stall.
- R2: While reset is asserted `host_status` reads zero (cleared immediately on assertion) and `imem_val` is low.
- R3: After reset release the first fetch uses address 0x00000000 with `imem_val` high, and sequential fetches advance the address by 4 per cycle.
- R4: ALU operations follow the standard 32-bit encodings: register form opcode 0110011 and immediate form opcode 0010011, funct3 000 add (bit 30 set in register form = subtract), 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 shift right (bit 30 set = arithmetic), 110 or, 111 and; shift amounts use the low 5 bits; opcode 0110111 loads a 20-bit upper immediate.
- R5: Word load (opcode 0000011, funct3 010) drives `dmem_val`=1, `dmem_rw`=0 and returns `dmem_rdata` to rd; word store (opcode 0100011, funct3 010) drives `dmem_val`=1, `dmem_rw`=1 with rs2 on `dmem_wdata`; address is rs1 plus the sign-extended offset.
- R6: A control write (opcode 1110011, funct3 001, control number 16 in bits 31:20) copies rs1 into `host_status`; the same instruction naming any other control number leaves `host_status` unchanged.
- R7: Register 0 always reads as zero; writes to it are discarded.
- R8: Branches (opcode 1100011; funct3 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110/111 unsigned forms) and jump-and-link (opcode 1101111, rd gets pc+4) redirect fetch to pc plus offset on the next cycle and squash the word fetched in the resolving cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 32 | Fetch address |
| imem_val | output | 1 | Fetch request valid |
| imem_data | input | 32 | Instruction word, returned in the same cycle |
| dmem_val | output | 1 | Data request valid |
| dmem_rw | output | 1 | 0 = load, 1 = store |
| dmem_addr | output | 32 | Data address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, returned in the same cycle |
| host_status | output | 32 | Host status register |

## Verification
The collision that matters is a taken branch or jump resolving in stage two in the same cycle that stage one fetches the next sequential word. Test programs place an instruction with a distinctive effect (adding 100 or 64 to an accumulator) directly behind every taken transfer and a counted increment behind a not-taken one, then publish the accumulator through the host status register; any leaked squashed instruction shows up as a wrong sum. A second overlap, a store followed at once by a load of the same word, is judged the same way through the published value and the bench's data memory contents.

// File: rtl/core_pkg.sv
`timescale 1ns/1ps
package core_pkg;

  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_SYS    = 7'b1110011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

endpackage

// File: rtl/core_rst_sync.sv
`timescale 1ns/1ps
module core_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/core_fetch.sv
`timescale 1ns/1ps
module core_fetch #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            redirect_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [31:0]     fetch_data_i,
  output logic [XLEN-1:0] fetch_addr_o,
  output logic            fetch_val_o,
  output logic [31:0]     ir_o,
  output logic [XLEN-1:0] pc_e_o,
  output logic            vld_e_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            run_q, run_d;
  logic [XLEN-1:0] pc_q, pc_d, pce_q, pce_d;
  logic [31:0]     ir_q, ir_d;
  logic            vld_q, vld_d;

  always_comb begin
    run_d = 1'b1;
    pc_d  = pc_q;
    pce_d = pce_q;
    ir_d  = ir_q;
    vld_d = 1'b0;
    if (run_q) begin
      if (redirect_i) begin
        pc_d = target_i;
      end else begin
        pc_d  = pc_q + STEP;
        ir_d  = fetch_data_i;
        pce_d = pc_q;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q <= 1'b0;
      pc_q  <= XLEN'(RESET_PC);
      pce_q <= '0;
      ir_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      run_q <= run_d;
      pc_q  <= pc_d;
      pce_q <= pce_d;
      ir_q  <= ir_d;
      vld_q <= vld_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign fetch_val_o  = run_q;
  assign ir_o         = ir_q;
  assign pc_e_o       = pce_q;
  assign vld_e_o      = vld_q;
endmodule

// File: rtl/core_regfile.sv
`timescale 1ns/1ps
module core_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [XLEN-1:0]         wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [XLEN-1:0]         rd1,
  output logic [XLEN-1:0]         rd2
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs_q[wa] <= wd;
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
  end
endmodule

// File: rtl/core_alu.sv
`timescale 1ns/1ps
module core_alu
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int SHW = $clog2(XLEN);
  logic [SHW-1:0] sh;

  always_comb begin
    sh = b[SHW-1:0];
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU:  y = {{(XLEN-1){1'b0}}, (a < b)};
      ALU_SLL:   y = a << sh;
      ALU_SRL:   y = a >> sh;
      ALU_SRA:   y = $unsigned($signed(a) >>> sh);
      default:   y = b;
    endcase
  end
endmodule

// File: rtl/pipe2_core.sv
`timescale 1ns/1ps
module pipe2_core
  import core_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [11:0] HOST_CSR = 12'h010
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  output logic            imem_val,
  input  logic [31:0]     imem_data,
  output logic            dmem_val,
  output logic            dmem_rw,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic [XLEN-1:0] host_status
);
  localparam int RAW = $clog2(NREG);

  logic            rst_sn;
  logic [31:0]     ir;
  logic [XLEN-1:0] pc_e;
  logic            vld_e;
  logic            redirect;
  logic [XLEN-1:0] br_target;

  logic [XLEN-1:0] rs1v, rs2v, alu_b, alu_y, wb_data;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_j, imm_u, imm;
  alu_op_e         alu_op;
  wb_sel_e         wb_sel;
  logic            use_imm, rf_we, is_ld, is_st, csr_we, take;
  logic [XLEN-1:0] host_q;

  function automatic alu_op_e op_from_f3(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  core_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  core_fetch #(.XLEN(XLEN)) u_fetch (
    .clk(clk), .rst_sn(rst_sn), .redirect_i(redirect), .target_i(br_target),
    .fetch_data_i(imem_data), .fetch_addr_o(imem_addr), .fetch_val_o(imem_val),
    .ir_o(ir), .pc_e_o(pc_e), .vld_e_o(vld_e)
  );

  core_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(rf_we), .wa(ir[7 +: RAW]), .wd(wb_data),
    .ra1(ir[15 +: RAW]), .ra2(ir[20 +: RAW]), .rd1(rs1v), .rd2(rs2v)
  );

  core_alu #(.XLEN(XLEN)) u_alu (
    .op(alu_op), .a(rs1v), .b(alu_b), .y(alu_y)
  );

  assign imm_i = {{(XLEN-12){ir[31]}}, ir[31:20]};
  assign imm_s = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
  assign imm_b = {{(XLEN-12){ir[31]}}, ir[7], ir[30:25], ir[11:8], 1'b0};
  assign imm_j = {{(XLEN-20){ir[31]}}, ir[19:12], ir[20], ir[30:21], 1'b0};
  assign imm_u = {{(XLEN-32){ir[31]}}, ir[31:12], 12'b0};

  always_comb begin
    case (ir[14:12])
      3'b000:  take = (rs1v == rs2v);
      3'b001:  take = (rs1v != rs2v);
      3'b100:  take = ($signed(rs1v) <  $signed(rs2v));
      3'b101:  take = ($signed(rs1v) >= $signed(rs2v));
      3'b110:  take = (rs1v <  rs2v);
      3'b111:  take = (rs1v >= rs2v);
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    alu_op   = ALU_ADD;
    wb_sel   = WB_ALU;
    use_imm  = 1'b0;
    imm      = imm_i;
    rf_we    = 1'b0;
    is_ld    = 1'b0;
    is_st    = 1'b0;
    csr_we   = 1'b0;
    redirect = 1'b0;
    case (ir[6:0])
      OPC_OPIMM: begin
        use_imm = 1'b1;
        rf_we   = 1'b1;
        alu_op  = op_from_f3(ir[14:12], (ir[14:12] == 3'b101) && ir[30]);
      end
      OPC_OP: begin
        rf_we  = 1'b1;
        alu_op = op_from_f3(ir[14:12], ir[30]);
      end
      OPC_LOAD: if (ir[14:12] == 3'b010) begin
        use_imm = 1'b1;
        is_ld   = 1'b1;
        rf_we   = 1'b1;
        wb_sel  = WB_MEM;
      end
      OPC_STORE: if (ir[14:12] == 3'b010) begin
        use_imm = 1'b1;
        imm     = imm_s;
        is_st   = 1'b1;
      end
      OPC_BRANCH: redirect = take;
      OPC_JAL: begin
        rf_we    = 1'b1;
        wb_sel   = WB_LINK;
        redirect = 1'b1;
      end
      OPC_LUI: begin
        use_imm = 1'b1;
        imm     = imm_u;
        rf_we   = 1'b1;
        alu_op  = ALU_PASSB;
      end
      OPC_SYS: csr_we = (ir[14:12] == 3'b001) && (ir[31:20] == HOST_CSR);
      default: ;
    endcase
    rf_we    = rf_we    & vld_e;
    is_ld    = is_ld    & vld_e;
    is_st    = is_st    & vld_e;
    csr_we   = csr_we   & vld_e;
    redirect = redirect & vld_e;
  end

  assign alu_b     = use_imm ? imm : rs2v;
  assign br_target = pc_e + ((ir[6:0] == OPC_JAL) ? imm_j : imm_b);

  always_comb begin
    case (wb_sel)
      WB_MEM:  wb_data = dmem_rdata;
      WB_LINK: wb_data = pc_e + XLEN'(4);
      default: wb_data = alu_y;
    endcase
  end

  assign dmem_val   = is_ld | is_st;
  assign dmem_rw    = is_st;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2v;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     host_q <= '0;
    else if (csr_we) host_q <= rs1v;
  end

  assign host_status = host_q;
endmodule

// File: rtl/pipe2_core_chk.sv
`timescale 1ns/1ps
module pipe2_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imem_val,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_val,
  input logic [XLEN-1:0] host_status,
  input logic            vld_e,
  input logic            redirect,
  input logic [XLEN-1:0] br_target,
  input logic            csr_we
);
  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imem_val) |-> (imem_addr == '0));                          // R3

  AST_SQUASH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !vld_e);                                            // R8

  AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (imem_addr == $past(br_target)));                   // R8

  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_e |-> (!dmem_val && !csr_we));                              // R5

  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status != $past(host_status)) |-> $past(csr_we));          // R6
endmodule

bind pipe2_core pipe2_core_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_val(imem_val), .imem_addr(imem_addr),
  .dmem_val(dmem_val), .host_status(host_status), .vld_e(vld_e),
  .redirect(redirect), .br_target(br_target), .csr_we(csr_we)
);

// File: tb/tb_pipe2_core.sv
`timescale 1ns/1ps
module tb_pipe2_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, host_status;
  logic        imem_val, dmem_val, dmem_rw;

  logic [31:0] prog [32];
  logic [31:0] dmem [16];
  int          ncmp = 0;
  int          nbad = 0;
  int          pi   = 0;

  always #10 clk = ~clk;

  pipe2_core dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_val(imem_val),
    .imem_data(imem_data), .dmem_val(dmem_val), .dmem_rw(dmem_rw),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .host_status(host_status)
  );

  assign imem_data  = prog[imem_addr[6:2]];
  assign dmem_rdata = dmem[dmem_addr[5:2]];
  always @(posedge clk) if (dmem_val && dmem_rw) dmem[dmem_addr[5:2]] <= dmem_wdata;

  localparam logic [6:0] OP_IMM = 7'b0010011;
  localparam logic [6:0] OP_REG = 7'b0110011;
  localparam logic [31:0] NOP   = 32'h00000013;

  // Vector table: operands, funct7, funct3, immediate form flag, expected result (R4)
  localparam int NV = 13;
  localparam logic [31:0] VA [NV] = '{32'd7, 32'd5, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFF0000,
    32'hFFFFFFFB, 32'hFFFFFFFB, 32'd1, 32'h80000000, 32'h80000000, 32'd100, 32'h0000FFFF, 32'hFFFFFFFF};
  localparam logic [31:0] VB [NV] = '{32'd5, 32'd7, 32'hFF00FF00, 32'h000000FF, 32'h0F0F0F0F,
    32'd3, 32'd3, 32'h3F, 32'd4, 32'd4, 32'hFFFFFFFF, 32'h00000FFF, 32'd0};
  localparam logic [6:0] VF7 [NV] = '{7'h00, 7'h20, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00,
    7'h00, 7'h00, 7'h20, 7'h00, 7'h00, 7'h00};
  localparam logic [2:0] VF3 [NV] = '{3'd0, 3'd0, 3'd7, 3'd6, 3'd4, 3'd2, 3'd3,
    3'd1, 3'd5, 3'd5, 3'd0, 3'd4, 3'd2};
  localparam logic VIM [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] VX [NV] = '{32'd12, 32'hFFFFFFFE, 32'hF000F000, 32'h0F0F00FF, 32'hF0F00F0F,
    32'd1, 32'd0, 32'h80000000, 32'h08000000, 32'hF8000000, 32'd99, 32'hFFFF0000, 32'd1};

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2, rs1,
                                      input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OP_REG};
  endfunction
  function automatic logic [31:0] e_i(input logic [11:0] im, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] e_s(input logic [11:0] im, input logic [4:0] rs2, rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input logic [12:0] im, input logic [4:0] rs2, rs1,
                                      input logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(input logic [20:0] im, input logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] e_c(input logic [11:0] cn, input logic [4:0] rs1);
    return {cn, rs1, 3'b001, 5'd0, 7'b1110011};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 32; i++) prog[i] = NOP;
    pi = 0;
  endtask
  task automatic put(input logic [31:0] w);
    prog[pi] = w;
    pi++;
  endtask
  task automatic ldc(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) >> 12;
    put({hi[19:0], rd, 7'b0110111});
    put(e_i(v[11:0], rd, 3'd0, rd, OP_IMM));
  endtask
  task automatic halt_put();
    put(e_b(13'd0, 5'd0, 5'd0, 3'd0));
  endtask
  task automatic run_prog();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #4ms;
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    clr();
    repeat (2) @(negedge clk);
    // R2: state during reset
    chk("R2 imem_val in reset", {31'd0, imem_val}, 32'd0);
    chk("R2 host_status in reset", host_status, 32'd0);

    // R4: ALU vector table
    for (int v = 0; v < NV; v++) begin
      clr();
      ldc(5'd1, VA[v]);
      if (VIM[v]) put(e_i(VB[v][11:0], 5'd1, VF3[v], 5'd3, OP_IMM));
      else begin
        ldc(5'd2, VB[v]);
        put(e_r(VF7[v], 5'd2, 5'd1, VF3[v], 5'd3));
      end
      put(e_c(12'h010, 5'd3));
      halt_put();
      run_prog();
      chk($sformatf("R4 vector %0d", v), host_status, VX[v]);
    end

    // R2: asserting reset clears a nonzero status at once
    clr();
    put(e_i(12'd77, 5'd0, 3'd0, 5'd1, OP_IMM));
    put(e_c(12'h010, 5'd1));
    halt_put();
    run_prog();
    chk("R6 status written", host_status, 32'd77);
    rst_n = 1'b0;
    #1;
    chk("R2 async clear", host_status, 32'd0);

    // R3: first fetch at zero, then +4 per cycle
    clr();
    halt_put();
    prog[0] = NOP;
    prog[5] = e_b(13'd0, 5'd0, 5'd0, 3'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) if (!imem_val) @(negedge clk);
    chk("R3 first fetch valid", {31'd0, imem_val}, 32'd1);
    chk("R3 first fetch addr", imem_addr, 32'h0);
    @(negedge clk);
    chk("R3 second fetch addr", imem_addr, 32'h4);
    @(negedge clk);
    chk("R3 third fetch addr", imem_addr, 32'h8);

    // R1: back-to-back dependent chain
    clr();
    put(e_i(12'd5, 5'd0, 3'd0, 5'd1, OP_IMM));
    put(e_i(12'd3, 5'd1, 3'd0, 5'd2, OP_IMM));
    put(e_r(7'h00, 5'd1, 5'd2, 3'd0, 5'd3));
    put(e_c(12'h010, 5'd3));
    halt_put();
    run_prog();
    chk("R1 dependent chain", host_status, 32'd13);

    // R7: register 0 stays zero
    clr();
    put(e_i(12'd7, 5'd0, 3'd0, 5'd0, OP_IMM));
    put(e_i(12'd1, 5'd0, 3'd0, 5'd3, OP_IMM));
    put(e_r(7'h00, 5'd0, 5'd3, 3'd0, 5'd3));
    put(e_c(12'h010, 5'd3));
    halt_put();
    run_prog();
    chk("R7 x0 reads zero", host_status, 32'd1);

    // R5: store then immediate load of the same word
    clr();
    put(e_i(12'h123, 5'd0, 3'd0, 5'd1, OP_IMM));
    put(e_s(12'd8, 5'd1, 5'd0));
    put(e_i(12'd8, 5'd0, 3'b010, 5'd2, 7'b0000011));
    put(e_i(12'd1, 5'd2, 3'd0, 5'd2, OP_IMM));
    put(e_c(12'h010, 5'd2));
    halt_put();
    run_prog();
    chk("R5 stored word", dmem[2], 32'h123);
    chk("R5 load result", host_status, 32'h124);

    // R8: not-taken, taken and signed branches with markers behind them
    clr();
    put(e_i(12'd1, 5'd0, 3'd0, 5'd1, OP_IMM));
    put(e_b(13'd8, 5'd0, 5'd0, 3'b001));
    put(e_i(12'd4, 5'd1, 3'd0, 5'd1, OP_IMM));
    put(e_b(13'd8, 5'd0, 5'd0, 3'b000));
    put(e_i(12'd100, 5'd1, 3'd0, 5'd1, OP_IMM));
    put(e_i(12'd2, 5'd1, 3'd0, 5'd1, OP_IMM));
    put(e_i(12'hFFF, 5'd0, 3'd0, 5'd4, OP_IMM));
    put(e_b(13'd8, 5'd0, 5'd4, 3'b100));
    put(e_i(12'd64, 5'd1, 3'd0, 5'd1, OP_IMM));
    put(e_c(12'h010, 5'd1));
    halt_put();
    run_prog();
    chk("R8 branch squash sum", host_status, 32'd7);

    // R8: jump-and-link writes pc+4 and skips two words
    clr();
    put(e_i(12'd0, 5'd0, 3'd0, 5'd6, OP_IMM));
    put(e_j(21'd12, 5'd5));
    put(e_i(12'd50, 5'd0, 3'd0, 5'd6, OP_IMM));
    put(e_i(12'd50, 5'd6, 3'd0, 5'd6, OP_IMM));
    put(e_r(7'h00, 5'd6, 5'd5, 3'd0, 5'd7));
    put(e_c(12'h010, 5'd7));
    halt_put();
    run_prog();
    chk("R8 jump link value", host_status, 32'd8);

    // R6: other control number has no effect, then number 16 does
    clr();
    put(e_i(12'd9, 5'd0, 3'd0, 5'd1, OP_IMM));
    put(e_c(12'h011, 5'd1));
    halt_put();
    run_prog();
    chk("R6 other control ignored", host_status, 32'd0);
    clr();
    put(e_i(12'd9, 5'd0, 3'd0, 5'd1, OP_IMM));
    put(e_c(12'h011, 5'd1));
    put(e_i(12'd3, 5'd0, 3'd0, 5'd2, OP_IMM));
    put(e_c(12'h010, 5'd2));
    halt_put();
    run_prog();
    chk("R6 status after mixed writes", host_status, 32'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule